// File: doc/BRIEF.md
# Interrupt Summary Aggregator

This block gathers the interrupt lines of three cause groups (receive, transmit and miscellaneous) into one small summary register and drives a single level interrupt to the host. Each summary bit remembers that its group line was active since software last looked. Reading the summary register returns the gathered bits and clears them in the same access, so software needs no acknowledge write.

A software mask register sits between the summary bits and the host line. Software disables the host line by writing all ones to the mask. It enables the line again by writing a value whose three group positions are zero. The per-group cause registers live outside this block and reach it only as the three group lines.

The register port is a simple single-cycle access port. Read data is combinational from the current register state. Writes and the clearing effect of a read take place at the rising clock edge of the access cycle.

Top module: `irq_summary_agg`

## Requirements
- R1: After reset the summary register reads 0, the mask register reads all ones and host_irq is low.
- R2: The summary register is at address 0. Bit 0 is receive (grp_irq[0]), bit 1 is transmit (grp_irq[1]) and bit 2 is miscellaneous (grp_irq[2]). All other bits of a summary read are 0.
- R3: A group line that is high in a cycle sets its summary bit from the next cycle on. The bit stays set until the summary register is read, even after the line falls.
- R4: A read of address 0 returns the current summary bits. From the next cycle on, each bit equals the level its group line had during the read cycle, so a line still high during the read sets its bit again.
- R5: A write to address 0 has no effect on the summary bits.
- R6: The mask register is at address 1. A write to it stores the full 32-bit write data, and a read of it returns that value.
- R7: host_irq is high exactly when some summary bit is 1 and the mask bit at the same position is 0.
- R8: With mask bits 2..0 all ones, host_irq stays low whatever the groups do. Mask bits above bit 2 never affect host_irq.
- R9: A read of the mask address leaves the summary bits unchanged. Reads of addresses 2 and 3 return 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_irq | input | 3 | Group interrupt lines: bit 0 receive, bit 1 transmit, bit 2 miscellaneous |
| reg_addr | input | 2 | Register address: 0 summary, 1 mask |
| reg_wr | input | 1 | Write strobe for the access cycle |
| reg_rd | input | 1 | Read strobe for the access cycle; a summary read clears it |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The bench sweeps every combination of the eight group pulse patterns and the eight low mask patterns. For each pair it checks the gathered summary value and the host line, which separates a mask polarity or bit-position error from a latching error. Each pattern is followed by a second read to show that the clear works. A read with the lines held high shows that a still-active line is caught again rather than lost. Further checks cover writes to the summary address, reads of the mask and unused addresses, and high mask bits. These tell a summary that reacts to the wrong access apart from one that truly ignores it.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;

    // Group positions in the summary register; neighbours decode these.
    typedef enum int unsigned {
        GRP_RX   = 0,
        GRP_TX   = 1,
        GRP_MISC = 2
    } grp_idx_e;

    localparam int unsigned GRP_COUNT = 3;

    // Register addresses on the access port.
    localparam logic [1:0] ADR_SUMMARY = 2'd0;
    localparam logic [1:0] ADR_MASK    = 2'd1;

endpackage

// File: rtl/irqsum_sticky.sv
module irqsum_sticky #(
    parameter int unsigned NUM_GRP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] grp_in,
    input  logic               clr,
    output logic [NUM_GRP-1:0] sum_q
);

    typedef struct packed {
        logic [NUM_GRP-1:0] sum;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_GRP; i++) begin
            if (clr) begin
                st_d.sum[i] = grp_in[i];
            end else begin
                st_d.sum[i] = st_q.sum[i] | grp_in[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_q = st_q.sum;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        // R3: an active line is caught on the next cycle
        p_catch_r3: assert property (@(posedge clk) disable iff (!rst_n)
            grp_in[g] |=> sum_q[g]);
        // R3: a caught bit holds until a clearing read
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sum_q[g] && !clr) |=> sum_q[g]);
        // R4: after a clearing read the bit follows the line level of the read cycle
        p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !grp_in[g]) |=> !sum_q[g]);
    end

endmodule

// File: rtl/irqsum_maskreg.sv
module irqsum_maskreg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q
);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;

    // R6: mask changes only through a write
    p_mask_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask_q));

endmodule

// File: rtl/irqsum_regdec.sv
module irqsum_regdec
    import irqsum_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned NUM_GRP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic               wr,
    input  logic [NUM_GRP-1:0] sum,
    input  logic [DATA_W-1:0]  mask,
    output logic               sum_clr,
    output logic               mask_wr,
    output logic [DATA_W-1:0]  rdata
);

    localparam int unsigned PAD_W = DATA_W - NUM_GRP;

    logic hit_sum, hit_mask;

    assign hit_sum  = (addr == ADDR_W'(ADR_SUMMARY));
    assign hit_mask = (addr == ADDR_W'(ADR_MASK));
    assign sum_clr  = rd & hit_sum;
    assign mask_wr  = wr & hit_mask;

    always_comb begin
        rdata = '0;
        if (hit_sum) begin
            rdata = {{PAD_W{1'b0}}, sum};
        end else if (hit_mask) begin
            rdata = mask;
        end
    end

    // R2: summary reads carry nothing above the group bits
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_sum |-> (rdata[DATA_W-1:NUM_GRP] == '0));
    // R5: a write never clears the summary
    p_wr_noclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd) |-> !sum_clr);

endmodule

// File: rtl/irq_summary_agg.sv
module irq_summary_agg
    import irqsum_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned NUM_GRP = GRP_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] grp_irq,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               host_irq
);

    logic [NUM_GRP-1:0] sum_q;
    logic [DATA_W-1:0]  mask_q;
    logic               sum_clr;
    logic               mask_wr;

    irqsum_sticky #(.NUM_GRP(NUM_GRP)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .grp_in (grp_irq),
        .clr    (sum_clr),
        .sum_q  (sum_q)
    );

    irqsum_maskreg #(.DATA_W(DATA_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (mask_wr),
        .wdata  (reg_wdata),
        .mask_q (mask_q)
    );

    irqsum_regdec #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NUM_GRP (NUM_GRP)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .rd      (reg_rd),
        .wr      (reg_wr),
        .sum     (sum_q),
        .mask    (mask_q),
        .sum_clr (sum_clr),
        .mask_wr (mask_wr),
        .rdata   (reg_rdata)
    );

    assign host_irq = |(sum_q & ~mask_q[NUM_GRP-1:0]);

    // R8: a fully masked group field keeps the host line low
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q[NUM_GRP-1:0]) |-> !host_irq);
    // R7: the host line needs a pending summary bit
    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (|sum_q));
    // R1: leaving reset the summary is empty and the line is low
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (sum_q == '0) && !host_irq);

endmodule

// File: tb/irq_summary_agg_test.sv
module irq_summary_agg_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  grp_irq = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_summary_agg uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_irq   (grp_irq),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .host_irq  (host_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Returns data seen during the read cycle; the clearing edge follows.
    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] p);
        @(negedge clk);
        grp_irq = p;
        @(negedge clk);
        grp_irq = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'b0, host_irq}, 32'h0);
        rd_reg(2'd1, d); check("R1 mask", d, 32'hFFFF_FFFF);
        rd_reg(2'd0, d); check("R1 summary", d, 32'h0);

        // Sweep all group patterns against all low mask patterns.
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
                wr_reg(2'd1, {29'h0, 3'(m)});
                rd_reg(2'd0, d);
                pulse(3'(p));
                repeat (2) @(negedge clk);
                // R3 caught, R7 host line
                check("R7 irq", {31'b0, host_irq}, {31'b0, |(3'(p) & ~3'(m))});
                rd_reg(2'd0, d);
                check("R2 R3 summary", d, {29'h0, 3'(p)});
                rd_reg(2'd0, d);
                check("R4 cleared", d, 32'h0);
                check("R7 irq after clear", {31'b0, host_irq}, 32'h0);
            end
        end

        // R4 line held high through the read is caught again
        wr_reg(2'd1, 32'h0);
        @(negedge clk); grp_irq = 3'b101;
        rd_reg(2'd0, d);
        check("R4 read while high", d, 32'h5);
        grp_irq = 3'b000;
        @(negedge clk);
        check("R4 irq re-set", {31'b0, host_irq}, 32'h1);
        rd_reg(2'd0, d);
        check("R4 re-caught", d, 32'h5);

        // R5 write to summary address ignored
        pulse(3'b011);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        check("R5 irq kept", {31'b0, host_irq}, 32'h1);
        rd_reg(2'd1, d);
        check("R9 mask read", d, 32'h0);
        rd_reg(2'd2, d);
        check("R9 addr2 zero", d, 32'h0);
        rd_reg(2'd3, d);
        check("R9 addr3 zero", d, 32'h0);
        rd_reg(2'd0, d);
        check("R5 R9 summary kept", d, 32'h3);

        // R6 full-width mask storage
        wr_reg(2'd1, 32'hA5C3_0F96);
        rd_reg(2'd1, d);
        check("R6 mask readback", d, 32'hA5C3_0F96);

        // R8 upper mask bits do not matter
        wr_reg(2'd1, 32'hFFFF_FFF8);
        pulse(3'b100);
        @(negedge clk);
        check("R8 upper bits set, low clear", {31'b0, host_irq}, 32'h1);
        wr_reg(2'd1, 32'h0000_0007);
        check("R8 low bits set", {31'b0, host_irq}, 32'h0);
        wr_reg(2'd1, 32'h0000_0000);
        check("R7 unmask pending", {31'b0, host_irq}, 32'h1);
        rd_reg(2'd0, d);
        check("R2 misc position", d, 32'h4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule